// File: doc/BRIEF.md
# Serial Register Bridge with In-Band Retry

This block is a serial-peripheral slave that turns host frames into 16-bit register cycles on a Wishbone-style bus. Its clock is the serial clock itself. An active-low select frames the traffic, and the bus master is clocked by that same serial clock. A frame is 24 bits long and is sampled on the rising clock edge, most significant bit first. The first bit chooses a write (1) or a read (0). The next four bits are the register address, MSB first.

The slave cannot stall the serial clock. Instead it reports, inside the frame, whether the bus cycle finished. Three status bits come back from the slave, and the host resends the frame when all three are zero. On a read the host may resend at once without releasing select. A read with its burst flag set keeps reading the same address in 16-bit groups. A write chains further words to the same address for as long as select stays low, and the next word's top three bits travel in the last three bit times of each frame or group.

The controller has five states. ST_HDR collects the header. ST_RD_ACK and ST_WR_ACK are the three-bit status windows. ST_RD_DATA shifts read data out. ST_WR_DATA gathers write data. The transitions are named as follows:
- hdr_to_rd (header complete, read)
- hdr_to_wr (header complete, write)
- rdack_to_data (window closed)
- rddata_loop (burst group follows)
- rddata_to_hdr (burst flag clear)
- wrdata_to_ack (word complete)
- wrack_to_data (window closed, continuation word)
- any_to_hdr (select released)

Top module: `srb_bridge`

## Requirements
- R1: In reset, and on any edge where select is high, the bus cycle signal is low. `miso` is 0 while select is high.
- R2: Bit 23 of a frame is the write flag and bits 22..19 are the address. On a read, `wb_cyc_o`/`wb_stb_o` rise on the edge that samples bit 19, with `wb_we_o`=0 and `wb_adr_o` set to the address.
- R3: The three status bits of a read occupy frame bits 18..16. Each bit is 1 exactly when the bus ack was high at or before the edge on which the host samples that bit. If the acknowledge takes W edges, the status is {W==0, W<=1, W<=2}. The cycle is dropped at the ack, or at the latest on the third window edge.
- R4: Read data follows in frame bits 15..0, MSB first. It is the value present on `wb_dat_i` at the acknowledging edge, or 0 if no ack came in the window.
- R5: After a read frame whose burst flag is clear, a new 24-bit frame may follow at once without releasing select. A retried read then returns status 3'b111 when acknowledged immediately.
- R6: A write carries its data in frame bits 18..3, MSB first. The cycle starts on the edge that samples bit 3 and drives that word on `wb_dat_o`. Bits 2..0 return status by the rule of R3. A write that gets no ack leaves the target register unchanged.
- R7: Read bit 15 is the burst flag. When it is 1, a new read of the same address starts on the next edge. Its data appears in the next 16 bit times, and the first bit the host sends in each such 16-bit group is again the burst flag. A group sent with the flag clear ends the burst, and a fresh frame header follows.
- R8: A burst read cycle may be acknowledged on any of the 15 edges after it starts, which covers up to 14 wait states. Without an ack the word reads as 0.
- R9: In a write, the last three frame bits are bits 15..13 of the next word to the same address. Each further 16-bit group supplies the remaining 13 bits, starts the cycle, and returns status in its last three bit times under the R3 rule.
- R10: Releasing select mid-frame or mid-word discards the partial frame and issues no cycle for an incomplete word. The next frame is decoded from its first bit.
- R11: During a bus cycle, address, write flag and write data stay stable. The cycle ends on the edge after an ack and never stays high for more than 15 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock; also clocks the bus master |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Host-to-slave serial data |
| miso | output | 1 | Slave-to-host serial data (status and read data) |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | 4 | Register address |
| wb_dat_o | output | 16 | Write data |
| wb_dat_i | input | 16 | Read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
The assertions watch the bus side on every edge. A released select clears the cycle, an ack ends it on the next edge, address and data do not move while it runs, and no cycle outlives the 15-edge burst window. The bench scenarios cover the serial-side arithmetic: the status thermometer against each wait count, the read values, in-frame retry, burst chaining of reads and writes with their boundary wait counts, and the discarding of partial frames. These depend on bit positions and on the contents of the registers, which only full frames can reveal.

// File: rtl/srb_pkg.sv
package srb_pkg;
    typedef enum logic [2:0] {
        ST_HDR,
        ST_RD_ACK,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_WR_ACK
    } srb_state_e;
endpackage

// File: rtl/srb_rd_shift.sv
module srb_rd_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic              msb
);
    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= din;
        end else if (shift) begin
            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[DATA_W-1];
endmodule

// File: rtl/srb_wr_shift.sv
module srb_wr_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              din,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (en) begin
            sh_q <= {sh_q[DATA_W-2:0], din};
        end
    end

    // word as it stands once the bit on the wire is included
    assign word = {sh_q[DATA_W-2:0], din};
endmodule

// File: rtl/srb_wb_master.sv
module srb_wb_master #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              start,
    input  logic              close,
    input  logic [DATA_W-1:0] wdat,
    input  logic [DATA_W-1:0] dat_i,
    input  logic              ack_i,
    output logic              cyc,
    output logic [DATA_W-1:0] dat_o,
    output logic              ack_live,
    output logic [DATA_W-1:0] rd_word
);
    logic              seen_q;
    logic [DATA_W-1:0] rdat_q;
    logic              hit;

    assign hit = cyc && ack_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc    <= 1'b0;
            seen_q <= 1'b0;
            rdat_q <= '0;
            dat_o  <= '0;
        end else if (clr) begin
            cyc    <= 1'b0;
            seen_q <= 1'b0;
        end else if (start) begin
            cyc    <= 1'b1;
            seen_q <= 1'b0;
            rdat_q <= '0;
            dat_o  <= wdat;
        end else begin
            if (hit) begin
                seen_q <= 1'b1;
                rdat_q <= dat_i;
                cyc    <= 1'b0;
            end
            if (close) begin
                cyc <= 1'b0;
            end
        end
    end

    assign ack_live = seen_q || hit;
    assign rd_word  = hit ? dat_i : rdat_q;
endmodule

// File: rtl/srb_bridge.sv
module srb_bridge
    import srb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int ACK_W  = 3
) (
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack_i
);
    localparam int CNT_W    = $clog2(DATA_W) + 1;
    localparam int HDR_LAST = ADDR_W;
    localparam int ACK_LAST = ACK_W - 1;
    localparam int WD_LAST  = DATA_W - 1;
    localparam int WC_LAST  = DATA_W - ACK_W - 1;

    srb_state_e        state_q, nxt_state;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] hdr_q;
    logic              we_q;
    logic [ADDR_W-1:0] adr_q;
    logic              burst_q;
    logic              wcont_q;

    logic              cnt_zero, wb_start, wb_close, rd_load, rd_shift, wr_en;
    logic              hdr_done, wr_last;
    logic              rd_msb, ack_live, cyc;
    logic [DATA_W-1:0] wr_word, rd_word;

    assign hdr_done = (state_q == ST_HDR) && (cnt_q == CNT_W'(HDR_LAST));
    assign wr_last  = wcont_q ? (cnt_q == CNT_W'(WC_LAST)) : (cnt_q == CNT_W'(WD_LAST));

    // next state and per-edge controls
    always_comb begin
        nxt_state = state_q;
        cnt_zero  = 1'b0;
        wb_start  = 1'b0;
        wb_close  = 1'b0;
        rd_load   = 1'b0;
        rd_shift  = 1'b0;
        wr_en     = 1'b0;
        unique case (state_q)
            ST_HDR: begin
                if (hdr_done) begin
                    cnt_zero = 1'b1;
                    if (hdr_q[ADDR_W-1]) begin
                        nxt_state = ST_WR_DATA;            // hdr_to_wr
                    end else begin
                        nxt_state = ST_RD_ACK;             // hdr_to_rd
                        wb_start  = 1'b1;
                    end
                end
            end
            ST_RD_ACK: begin
                if (cnt_q == CNT_W'(ACK_LAST)) begin
                    nxt_state = ST_RD_DATA;                // rdack_to_data
                    cnt_zero  = 1'b1;
                    rd_load   = 1'b1;
                    wb_close  = 1'b1;
                end
            end
            ST_RD_DATA: begin
                if (cnt_q == '0) begin
                    wb_start = mosi;
                end
                if (cnt_q == CNT_W'(WD_LAST)) begin
                    cnt_zero = 1'b1;
                    if (burst_q) begin
                        rd_load  = 1'b1;                   // rddata_loop
                        wb_close = 1'b1;
                    end else begin
                        nxt_state = ST_HDR;                // rddata_to_hdr
                    end
                end else begin
                    rd_shift = 1'b1;
                end
            end
            ST_WR_DATA: begin
                wr_en = 1'b1;
                if (wr_last) begin
                    nxt_state = ST_WR_ACK;                 // wrdata_to_ack
                    cnt_zero  = 1'b1;
                    wb_start  = 1'b1;
                end
            end
            ST_WR_ACK: begin
                wr_en = 1'b1;
                if (cnt_q == CNT_W'(ACK_LAST)) begin
                    nxt_state = ST_WR_DATA;                // wrack_to_data
                    cnt_zero  = 1'b1;
                    wb_close  = 1'b1;
                end
            end
            default: nxt_state = ST_HDR;
        endcase
    end

    // state register
    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HDR;
        end else if (cs_n) begin
            state_q <= ST_HDR;                             // any_to_hdr
        end else begin
            state_q <= nxt_state;
        end
    end

    // counters and decoded header
    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            hdr_q   <= '0;
            we_q    <= 1'b0;
            adr_q   <= '0;
            burst_q <= 1'b0;
            wcont_q <= 1'b0;
        end else if (cs_n) begin
            cnt_q   <= '0;
            burst_q <= 1'b0;
            wcont_q <= 1'b0;
        end else begin
            cnt_q <= cnt_zero ? '0 : cnt_q + 1'b1;
            if (state_q == ST_HDR) begin
                hdr_q <= {hdr_q[ADDR_W-2:0], mosi};
            end
            if (hdr_done) begin
                we_q    <= hdr_q[ADDR_W-1];
                adr_q   <= {hdr_q[ADDR_W-2:0], mosi};
                wcont_q <= 1'b0;
            end
            if (state_q == ST_RD_DATA && cnt_q == '0) begin
                burst_q <= mosi;
            end
            if (state_q == ST_WR_ACK && cnt_q == CNT_W'(ACK_LAST)) begin
                wcont_q <= 1'b1;
            end
        end
    end

    srb_rd_shift #(.DATA_W(DATA_W)) i_rd (
        .clk   (sck),
        .rst_n (rst_n),
        .load  (rd_load),
        .shift (rd_shift),
        .din   (rd_word),
        .msb   (rd_msb)
    );

    srb_wr_shift #(.DATA_W(DATA_W)) i_wr (
        .clk   (sck),
        .rst_n (rst_n),
        .en    (wr_en && !cs_n),
        .din   (mosi),
        .word  (wr_word)
    );

    srb_wb_master #(.DATA_W(DATA_W)) i_wb (
        .clk      (sck),
        .rst_n    (rst_n),
        .clr      (cs_n),
        .start    (wb_start),
        .close    (wb_close),
        .wdat     (wr_word),
        .dat_i    (wb_dat_i),
        .ack_i    (wb_ack_i),
        .cyc      (cyc),
        .dat_o    (wb_dat_o),
        .ack_live (ack_live),
        .rd_word  (rd_word)
    );

    always_comb begin
        miso = 1'b0;
        if (!cs_n) begin
            unique case (state_q)
                ST_RD_ACK, ST_WR_ACK: miso = ack_live;
                ST_RD_DATA:           miso = rd_msb;
                default:              miso = 1'b0;
            endcase
        end
    end

    assign wb_cyc_o = cyc;
    assign wb_stb_o = cyc;
    assign wb_we_o  = we_q;
    assign wb_adr_o = adr_q;
endmodule

// File: rtl/srb_bridge_chk.sv
module srb_bridge_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input logic              rst_n,
    input logic              sck,
    input logic              cs_n,
    input logic              cyc,
    input logic              ack,
    input logic              we,
    input logic [ADDR_W-1:0] adr,
    input logic [DATA_W-1:0] dat
);
    logic [5:0] run_q;

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (cyc) begin
            run_q <= (run_q == 6'h3f) ? run_q : run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    AST_CS_ENDS_CYC: assert property (@(posedge sck) disable iff (!rst_n)
        cs_n |=> !cyc);                                               // R1
    AST_ACK_ENDS_CYC: assert property (@(posedge sck) disable iff (!rst_n)
        (cyc && ack) |=> !cyc);                                       // R11
    AST_BUS_STABLE: assert property (@(posedge sck) disable iff (!rst_n)
        (cyc && $past(cyc)) |-> ($stable(adr) && $stable(we) && $stable(dat))); // R11
    AST_CYC_BOUNDED: assert property (@(posedge sck) disable iff (!rst_n)
        run_q <= 6'd15);                                              // R8
endmodule

bind srb_bridge srb_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_srb_chk (
    .rst_n (rst_n),
    .sck   (sck),
    .cs_n  (cs_n),
    .cyc   (wb_cyc_o),
    .ack   (wb_ack_i),
    .we    (wb_we_o),
    .adr   (wb_adr_o),
    .dat   (wb_dat_o)
);

// File: tb/test_srb_bridge.sv
`timescale 1ns/1ps
module test_srb_bridge;
    logic        sck = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso, cyc, stb, we, ack;
    logic [3:0]  adr;
    logic [15:0] wdat, rdat;

    int total = 0;
    int bad = 0;

    always #2 sck = ~sck;

    srb_bridge i_srb_bridge (
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .miso     (miso),
        .wb_cyc_o (cyc),
        .wb_stb_o (stb),
        .wb_we_o  (we),
        .wb_adr_o (adr),
        .wb_dat_o (wdat),
        .wb_dat_i (rdat),
        .wb_ack_i (ack)
    );

    // register slave with programmable wait states
    logic [15:0] mem [16];
    logic [15:0] nrd;
    int          nwr;
    logic [5:0]  wcnt;
    logic [5:0]  wait_cfg = '0;

    assign ack  = cyc && stb && (wcnt >= wait_cfg);
    assign rdat = mem[adr] + nrd;

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
            nrd  <= '0;
            nwr  <= 0;
            wcnt <= '0;
        end else begin
            wcnt <= cyc ? wcnt + 1'b1 : '0;
            if (ack && we) begin
                mem[adr] <= wdat;
                nwr      <= nwr + 1;
            end
            if (ack && !we) nrd <= nrd + 1'b1;
        end
    end

    // expected state kept by the bench
    logic [15:0] exp_mem [16];
    logic [15:0] exp_nrd = '0;

    function automatic logic [2:0] ack_exp(input int w);
        return {w <= 0, w <= 1, w <= 2};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic xbit(input logic b, output logic r);
        @(negedge sck);
        r    = miso;
        cs_n = 1'b0;
        mosi = b;
    endtask

    task automatic xfer(input int n, input logic [23:0] tx, output logic [23:0] rx);
        rx = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic r;
            xbit(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic release_cs();
        @(negedge sck);
        cs_n = 1'b1;
        mosi = 1'b0;
        @(negedge sck);
    endtask

    task automatic read_one(input logic [3:0] a, input int w, input string tag);
        logic [23:0] rx;
        logic [15:0] e;
        wait_cfg = 6'(w);
        xfer(24, {1'b0, a, 19'h0}, rx);
        chk({tag, " R3 status"}, {29'h0, rx[18:16]}, {29'h0, ack_exp(w)});
        e = '0;
        if (w <= 2) begin
            e = exp_mem[a] + exp_nrd;
            exp_nrd++;
        end
        chk({tag, " R4 data"}, {16'h0, rx[15:0]}, {16'h0, e});
    endtask

    initial begin
        repeat (150000) @(posedge sck);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [23:0] rx;
        logic [15:0] wv [4];
        int          n0;
        for (int i = 0; i < 16; i++) exp_mem[i] = '0;
        repeat (3) @(negedge sck);
        chk("R1 reset cyc", {31'h0, cyc}, 32'h0);
        chk("R1 reset miso", {31'h0, miso}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge sck);

        // R2: read cycle starts right after the address
        wait_cfg = 6'd40;
        xfer(5, {19'h0, 1'b0, 4'hA}, rx);
        @(negedge sck);
        chk("R2 cyc after header", {31'h0, cyc}, 32'h1);
        chk("R2 address", {28'h0, adr}, 32'hA);
        chk("R2 read flag", {31'h0, we}, 32'h0);
        release_cs();
        chk("R1 cs high ends cycle", {31'h0, cyc}, 32'h0);

        // R6: write sweep over every address and wait count
        for (int a = 0; a < 16; a++) begin
            for (int w = 0; w < 4; w++) begin
                logic [15:0] d;
                d = 16'(a * 4099 + w * 257 + 16'h1234);
                wait_cfg = 6'(w);
                xfer(24, {1'b1, 4'(a), d, 3'b000}, rx);
                chk("R6 write status", {29'h0, rx[2:0]}, {29'h0, ack_exp(w)});
                if (w <= 2) exp_mem[a] = d;
                @(posedge sck);
                #1;
                chk("R11 write window closed", {31'h0, cyc}, 32'h0);
                release_cs();
            end
        end

        // R3 R4 R5: read sweep with in-frame retry after a miss
        for (int a = 0; a < 16; a++) begin
            for (int w = 0; w < 4; w++) begin
                read_one(4'(a), w, "sweep");
                if (w == 3) read_one(4'(a), 0, "R5 retry");
                release_cs();
            end
        end

        // R7: read burst at wait 1, then a fresh frame in the same select
        wait_cfg = 6'd1;
        xfer(24, {1'b0, 4'd5, 3'b000, 1'b1, 15'h0}, rx);
        chk("R7 burst first status", {29'h0, rx[18:16]}, 32'h3);
        chk("R7 burst first data", {16'h0, rx[15:0]}, {16'h0, exp_mem[5] + exp_nrd});
        exp_nrd++;
        for (int g = 0; g < 4; g++) begin
            xfer(16, {8'h0, (g < 3), 15'h0}, rx);
            chk("R7 burst group", {16'h0, rx[15:0]}, {16'h0, exp_mem[5] + exp_nrd});
            exp_nrd++;
        end
        read_one(4'd6, 1, "R7 after burst");
        release_cs();

        // R8: burst window boundary
        wait_cfg = 6'd13;
        xfer(24, {1'b0, 4'd9, 3'b000, 1'b1, 15'h0}, rx);
        chk("R8 slow frame status", {29'h0, rx[18:16]}, 32'h0);
        xfer(16, 24'h0, rx);
        chk("R8 13 waits", {16'h0, rx[15:0]}, {16'h0, exp_mem[9] + exp_nrd});
        exp_nrd++;
        release_cs();
        wait_cfg = 6'd15;
        xfer(24, {1'b0, 4'd9, 3'b000, 1'b1, 15'h0}, rx);
        xfer(16, 24'h0, rx);
        chk("R8 15 waits reads zero", {16'h0, rx[15:0]}, 32'h0);
        release_cs();

        // R9 R10: write burst of four words, trailing partial word dropped
        for (int k = 0; k < 4; k++) wv[k] = 16'(16'hA5C3 + k * 16'h1111);
        n0 = nwr;
        wait_cfg = 6'd2;
        xfer(24, {1'b1, 4'd11, wv[0], wv[1][15:13]}, rx);
        chk("R9 first status", {29'h0, rx[2:0]}, 32'h1);
        for (int k = 1; k < 4; k++) begin
            logic [2:0] top;
            top = (k < 3) ? wv[k+1][15:13] : 3'b101;
            xfer(16, {8'h0, wv[k][12:0], top}, rx);
            chk("R9 group status", {29'h0, rx[2:0]}, 32'h1);
        end
        xfer(5, {19'h0, 5'b10110}, rx);
        release_cs();
        chk("R10 write count", nwr - n0, 32'd4);
        exp_mem[11] = wv[3];
        read_one(4'd11, 0, "R9 burst result");
        release_cs();

        // R10: aborted header and aborted write data
        xfer(3, 24'h7, rx);
        release_cs();
        read_one(4'd2, 0, "R10 after abort");
        release_cs();
        n0 = nwr;
        xfer(12, {12'h0, 1'b1, 4'd3, 7'h7F}, rx);
        release_cs();
        chk("R10 no partial write", nwr - n0, 32'd0);
        read_one(4'd3, 0, "R10 register kept");
        release_cs();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule